// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits next to the program counter of a small in-order core and lets one repeat command run a run of following instructions a chosen number of times, with no branch instructions in the loop body and no lost fetch cycles. It compares the fetch address with the captured last address of the loop body. When they match and more passes remain, it sends a PC override back to the loop's first address in that same cycle.

Two command forms are accepted. The early form is resolved at fetch, in the cycle in which the repeat instruction's own address is on `fetchPc`. It carries an immediate pass count and an immediate body length. Exactly one spacer instruction follows it and runs once before the body starts. The late form resolves `LATE_DEPTH` stages further down the pipeline. Its pass count is a register value and its body length is an immediate. It leaves `LATE_DEPTH` spacer slots, and the body starts right after them. A late pass count of all ones loops with no end. Decode, the register file and branch resolution are outside the block, and the bench stands in for them.

Top module: `loop_seq`

## Requirements
- R1: After reset `loopActive`, `pcOvrValid`, `passesLeft` and `blockPos` are all 0.
- R2: An early command with count Y>0 and length N>0, issued while `fetchPc`=P, starts its body at P+2 and runs the N addresses P+2..P+N+1 exactly Y times. The spacer at P+1 runs once.
- R3: In a cycle where `fetchPc` equals the last body address and more than one pass remains, `pcOvrValid` is 1 in that same cycle and `pcOvrAddr` is the body start. On the final pass there is no override, the loop goes inactive and fetch continues with the next address.
- R4: A late command with count Y>0 and length N>0 for an instruction at address `latePc` starts its body at `latePc`+`LATE_DEPTH`+1 and runs the body Y times.
- R5: A late command with count 0x1FF loops forever. It stays active and `passesLeft` reads 0x1FF until a flush or a new command arrives.
- R6: An early command with count 0x1FF is finite and runs its body 511 times.
- R7: A command of either form with count 0 or length 0 leaves the sequencer idle. It also cancels any loop that was active.
- R8: `flush` clears the active loop with no override. It wins over a command in the same cycle.
- R9: A command issued while a loop is active replaces that loop. The new count, start and length apply from the next cycle.
- R10: When early and late commands arrive in the same cycle, the late (older) one is taken and the early one is dropped.
- R11: `passesLeft` shows the passes remaining including the current one (0 when idle) and falls by one at each wrap. `blockPos` is `fetchPc` minus the body start while the fetch address is inside the active body, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchPc | input | ADDR_W | Address being fetched this cycle |
| earlyValid | input | 1 | Early repeat command at the fetch address |
| earlyCount | input | 9 | Early immediate pass count |
| earlyLen | input | 9 | Early immediate body length |
| lateValid | input | 1 | Late repeat command resolving this cycle |
| lateCount | input | 9 | Late pass count from a register, 0x1FF = endless |
| lateLen | input | 9 | Late immediate body length |
| latePc | input | ADDR_W | Address of the late repeat instruction |
| flush | input | 1 | Taken branch or pipeline flush |
| pcOvrValid | output | 1 | Replace the next fetch address |
| pcOvrAddr | output | ADDR_W | Replacement fetch address (body start) |
| loopActive | output | 1 | A loop is armed |
| passesLeft | output | 9 | Remaining passes including the current one |
| blockPos | output | 9 | Offset of the fetch address inside the body |

## Verification
`pcOvrValid`, `pcOvrAddr` and `blockPos` are combinational from the registered loop state and the current `fetchPc`, so they are due in the same cycle as the fetch address they answer. `loopActive` and `passesLeft` reflect a command, flush or wrap one clock after it. The bench applies inputs just after a rising edge and compares every output at the following falling edge against a reference model. It updates that model only after the next rising edge, so each comparison pairs the current inputs with the state left by the previous cycle. Directed runs count how many times the body start is fetched, which gives the total pass count for each form and corner case.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
  localparam int CNT_W = 9;
  localparam logic [CNT_W-1:0] ENDLESS = '1;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic loadEarly;
    logic loadLate;
    logic wrap;
    logic clear;
  } loopStrobe_t;
endpackage

// File: rtl/loop_seq_ctrl.sv
module loop_seq_ctrl
  import loop_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        earlyValid,
  input  logic        earlyZero,
  input  logic        lateValid,
  input  logic        lateZero,
  input  logic        flush,
  input  logic        atEnd,
  input  logic        morePasses,
  output loopStrobe_t strobe,
  output logic        active
);

  always_comb begin
    strobe = '0;
    if (flush) begin
      strobe.clear = 1'b1;
    end else if (lateValid) begin
      if (lateZero) strobe.clear    = 1'b1;
      else          strobe.loadLate = 1'b1;
    end else if (earlyValid) begin
      if (earlyZero) strobe.clear     = 1'b1;
      else           strobe.loadEarly = 1'b1;
    end else if (active && atEnd) begin
      if (morePasses) strobe.wrap  = 1'b1;
      else            strobe.clear = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 active <= 1'b0;
    else if (strobe.loadEarly || strobe.loadLate) active <= 1'b1;
    else if (strobe.clear)                     active <= 1'b0;
  end

  // R8: a flush always leaves the sequencer idle
  p_flush_cancels_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !active);

  // R7: a degenerate command never arms a loop
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lateValid && lateZero) |=> !active);

  // R10: late command takes precedence over a same-cycle early one
  p_late_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && lateValid && earlyValid) |-> !strobe.loadEarly);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/loop_seq_dp.sv
module loop_seq_dp
  import loop_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LATE_DEPTH = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  loopStrobe_t       strobe,
  input  logic              active,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [CNT_W-1:0]  earlyCount,
  input  logic [CNT_W-1:0]  earlyLen,
  input  logic [CNT_W-1:0]  lateCount,
  input  logic [CNT_W-1:0]  lateLen,
  input  logic [ADDR_W-1:0] latePc,
  output logic              atEnd,
  output logic              morePasses,
  output logic [ADDR_W-1:0] loopStart,
  output logic [CNT_W-1:0]  passesLeft,
  output logic [CNT_W-1:0]  blockPos
);

  localparam logic [ADDR_W-1:0] EARLY_OFS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LATE_OFS  = ADDR_W'(LATE_DEPTH + 1);

  logic [ADDR_W-1:0] loopEnd;
  logic [CNT_W-1:0]  passes;
  logic              endless;
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] span;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopStart <= '0;
      loopEnd   <= '0;
      passes    <= '0;
      endless   <= 1'b0;
    end else if (strobe.loadLate) begin
      loopStart <= latePc + LATE_OFS;
      loopEnd   <= latePc + LATE_OFS + ADDR_W'(lateLen) - ADDR_W'(1);
      passes    <= lateCount;
      endless   <= (lateCount == ENDLESS);
    end else if (strobe.loadEarly) begin
      loopStart <= fetchPc + EARLY_OFS;
      loopEnd   <= fetchPc + EARLY_OFS + ADDR_W'(earlyLen) - ADDR_W'(1);
      passes    <= earlyCount;
      endless   <= 1'b0;
    end else if (strobe.wrap && !endless) begin
      passes <= passes - CNT_W'(1);
    end
  end

  assign atEnd      = (fetchPc == loopEnd);
  assign morePasses = endless || (passes > CNT_W'(1));
  assign passesLeft = active ? passes : '0;

  assign offs     = fetchPc - loopStart;
  assign span     = loopEnd - loopStart;
  assign blockPos = (active && offs <= span) ? offs[CNT_W-1:0] : '0;

  // R11: every finite wrap consumes exactly one pass
  p_wrap_decrements_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrap && !endless) |=> passes == $past(passes) - CNT_W'(1));

  // R5: an endless loop keeps its marker count across wraps
  p_endless_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrap && endless) |=> (endless && passes == ENDLESS));

endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LATE_DEPTH = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              earlyValid,
  input  logic [8:0]        earlyCount,
  input  logic [8:0]        earlyLen,
  input  logic              lateValid,
  input  logic [8:0]        lateCount,
  input  logic [8:0]        lateLen,
  input  logic [ADDR_W-1:0] latePc,
  input  logic              flush,
  output logic              pcOvrValid,
  output logic [ADDR_W-1:0] pcOvrAddr,
  output logic              loopActive,
  output logic [8:0]        passesLeft,
  output logic [8:0]        blockPos
);

  loopStrobe_t strobe;
  logic        active;
  logic        atEnd;
  logic        morePasses;
  logic        earlyZero;
  logic        lateZero;

  assign earlyZero = (earlyCount == '0) || (earlyLen == '0);
  assign lateZero  = (lateCount == '0)  || (lateLen == '0);

  loop_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .earlyValid (earlyValid),
    .earlyZero  (earlyZero),
    .lateValid  (lateValid),
    .lateZero   (lateZero),
    .flush      (flush),
    .atEnd      (atEnd),
    .morePasses (morePasses),
    .strobe     (strobe),
    .active     (active)
  );

  loop_seq_dp #(.ADDR_W(ADDR_W), .LATE_DEPTH(LATE_DEPTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .active     (active),
    .fetchPc    (fetchPc),
    .earlyCount (earlyCount),
    .earlyLen   (earlyLen),
    .lateCount  (lateCount),
    .lateLen    (lateLen),
    .latePc     (latePc),
    .atEnd      (atEnd),
    .morePasses (morePasses),
    .loopStart  (pcOvrAddr),
    .passesLeft (passesLeft),
    .blockPos   (blockPos)
  );

  assign pcOvrValid = strobe.wrap;
  assign loopActive = active;

  // R3: an override is only ever requested by an armed loop at its last address
  p_ovr_needs_loop_r3: assert property (@(posedge clk) disable iff (!rstN)
    pcOvrValid |-> loopActive);

  // R3: the wrap never lets the loop fall idle
  p_ovr_keeps_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    pcOvrValid |=> loopActive);

endmodule

// File: tb/loop_seq_test.sv
module loop_seq_test;
  localparam int ADDR_W = 16;
  localparam int D      = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] pc = '0;
  logic              earlyValid = 1'b0;
  logic [8:0]        earlyCount = '0;
  logic [8:0]        earlyLen = '0;
  logic              lateValid = 1'b0;
  logic [8:0]        lateCount = '0;
  logic [8:0]        lateLen = '0;
  logic [ADDR_W-1:0] latePc = '0;
  logic              flush = 1'b0;
  logic [ADDR_W-1:0] flushTarget = '0;
  logic              pcOvrValid;
  logic [ADDR_W-1:0] pcOvrAddr;
  logic              loopActive;
  logic [8:0]        passesLeft;
  logic [8:0]        blockPos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [ADDR_W-1:0] watchAddr = '1;
  int visits = 0;

  // reference model state
  logic              mActive = 1'b0;
  logic [ADDR_W-1:0] mStart = '0;
  logic [ADDR_W-1:0] mEnd = '0;
  logic [8:0]        mPasses = '0;
  logic              mInf = 1'b0;

  loop_seq #(.ADDR_W(ADDR_W), .LATE_DEPTH(D)) uut (
    .clk(clk), .rstN(rstN), .fetchPc(pc),
    .earlyValid(earlyValid), .earlyCount(earlyCount), .earlyLen(earlyLen),
    .lateValid(lateValid), .lateCount(lateCount), .lateLen(lateLen),
    .latePc(latePc), .flush(flush),
    .pcOvrValid(pcOvrValid), .pcOvrAddr(pcOvrAddr), .loopActive(loopActive),
    .passesLeft(passesLeft), .blockPos(blockPos)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit expOvr();
    return mActive && pc == mEnd && (mInf || mPasses > 1) && !flush
           && !earlyValid && !lateValid;
  endfunction

  function automatic int expPos();
    if (mActive && pc >= mStart && pc <= mEnd) return int'(pc - mStart);
    return 0;
  endfunction

  task automatic modelStep();
    logic ovr;
    ovr = expOvr();
    if (flush) begin
      mActive = 1'b0;
    end else if (lateValid) begin
      if (lateCount == 0 || lateLen == 0) mActive = 1'b0;
      else begin
        mActive = 1'b1; mStart = latePc + ADDR_W'(D + 1);
        mEnd = mStart + ADDR_W'(lateLen) - 1; mPasses = lateCount;
        mInf = (lateCount == 9'h1FF);
      end
    end else if (earlyValid) begin
      if (earlyCount == 0 || earlyLen == 0) mActive = 1'b0;
      else begin
        mActive = 1'b1; mStart = pc + 2;
        mEnd = mStart + ADDR_W'(earlyLen) - 1; mPasses = earlyCount; mInf = 1'b0;
      end
    end else if (mActive && pc == mEnd) begin
      if (mInf) ;
      else if (mPasses > 1) mPasses = mPasses - 1;
      else mActive = 1'b0;
    end
    if (flush) pc = flushTarget;
    else if (ovr) pc = mStart;
    else pc = pc + 1;
  endtask

  // one cycle: compare at the falling edge, advance after the rising edge
  task automatic tick();
    @(negedge clk);
    check(pcOvrValid == expOvr(), "R3 override valid", int'(pcOvrValid), int'(expOvr()));
    if (expOvr())
      check(pcOvrAddr == mStart, "R3 override address", int'(pcOvrAddr), int'(mStart));
    check(loopActive == mActive, "R2 loop active", int'(loopActive), int'(mActive));
    check(passesLeft == (mActive ? mPasses : 9'd0), "R11 passes left",
          int'(passesLeft), mActive ? int'(mPasses) : 0);
    check(int'(blockPos) == expPos(), "R11 block position", int'(blockPos), expPos());
    if (pc == watchAddr) visits++;
    @(posedge clk);
    #1;
    cycles++;
    modelStep();
    earlyValid = 1'b0; lateValid = 1'b0; flush = 1'b0;
  endtask

  task automatic jumpTo(input logic [ADDR_W-1:0] a);
    flush = 1'b1; flushTarget = a; tick();
  endtask

  task automatic early(input int cnt, input int len);
    earlyValid = 1'b1; earlyCount = 9'(cnt); earlyLen = 9'(len); tick();
  endtask

  task automatic late(input int cnt, input int len);
    lateValid = 1'b1; lateCount = 9'(cnt); lateLen = 9'(len);
    latePc = pc - ADDR_W'(D); tick();
  endtask

  task automatic runIdle(input int maxCycles);
    for (int i = 0; i < maxCycles && mActive; i++) tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    @(negedge clk);
    check(!loopActive && !pcOvrValid, "R1 reset idle", int'(loopActive), 0);
    check(passesLeft == 0 && blockPos == 0, "R1 reset status", int'(passesLeft), 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2: early, count 3, length 2 at address 10 -> body 12..13
    jumpTo(16'd10);
    watchAddr = 16'd12; visits = 0;
    early(3, 2);
    check(pc == 16'd11, "R2 spacer runs once", int'(pc), 11);
    runIdle(40);
    check(visits == 3, "R2 body start fetched count", visits, 3);
    check(pc == 16'd14, "R3 fall through after final pass", int'(pc), 14);

    // R4: late, count 2, length 3; instruction at 40 -> body 43..45
    jumpTo(16'd42);
    watchAddr = 16'd43; visits = 0;
    late(2, 3);
    runIdle(40);
    check(visits == 2, "R4 late body passes", visits, 2);
    check(pc == 16'd46, "R4 late fall through", int'(pc), 46);

    // R7: zero count / zero length
    early(0, 4);
    check(!loopActive, "R7 early count zero idle", int'(loopActive), 0);
    early(4, 0);
    check(!loopActive, "R7 early length zero idle", int'(loopActive), 0);
    early(5, 5);
    late(0, 3);
    check(!loopActive, "R7 late zero cancels loop", int'(loopActive), 0);

    // R8: flush mid-loop, flush beats a command
    early(6, 3);
    tick(); tick();
    jumpTo(16'd100);
    check(!loopActive && pc == 16'd100, "R8 flush cancels", int'(loopActive), 0);
    flush = 1'b1; flushTarget = 16'd120; early(4, 2);
    check(!loopActive, "R8 flush beats command", int'(loopActive), 0);

    // R9: replacement
    early(7, 4);
    tick(); tick();
    early(2, 1);
    check(passesLeft == 9'd2, "R9 replaced count", int'(passesLeft), 2);
    runIdle(20);

    // R10: both forms at once
    earlyValid = 1'b1; earlyCount = 9'd9; earlyLen = 9'd2;
    late(4, 3);
    check(passesLeft == 9'd4, "R10 late taken", int'(passesLeft), 4);
    runIdle(40);

    // R5: endless late loop
    jumpTo(16'd200);
    late(9'h1FF, 3);
    for (int i = 0; i < 1500; i++) tick();
    check(loopActive && passesLeft == 9'h1FF, "R5 endless still active",
          int'(passesLeft), 511);
    check(pc >= 16'd201 && pc <= 16'd203, "R5 fetch stays in body", int'(pc), 201);
    jumpTo(16'd300);
    check(!loopActive, "R5 endless ended by flush", int'(loopActive), 0);

    // R6: early 0x1FF is finite
    watchAddr = 16'd302; visits = 0;
    early(9'h1FF, 1);
    runIdle(2000);
    check(visits == 511, "R6 early max count passes", visits, 511);
    check(!loopActive, "R6 early max count ends", int'(loopActive), 0);

    // random mix
    watchAddr = '1;
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        earlyValid = 1'b1; earlyCount = 9'($urandom_range(0, 5));
        earlyLen = 9'($urandom_range(0, 6));
      end else if (r < 6 && pc >= ADDR_W'(D)) begin
        lateValid = 1'b1; latePc = pc - ADDR_W'(D);
        lateCount = ($urandom_range(0, 9) == 0) ? 9'h1FF : 9'($urandom_range(0, 5));
        lateLen = 9'($urandom_range(0, 6));
        if ($urandom_range(0, 3) == 0) begin
          earlyValid = 1'b1; earlyCount = 9'd3; earlyLen = 9'd2;
        end
      end else if (r < 8) begin
        flush = 1'b1; flushTarget = ADDR_W'($urandom_range(0, 500));
      end
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule